// File: doc/BRIEF.md
# Masked Read-Register Sequencer

This unit handles register readback for a byte-wide programmable DMA controller. The host uses one control port. Each byte written to that port is either decoded as a command or, right after the mask-load command, stored as the read mask. Each read strobe returns one of seven read registers. The 7-bit mask chooses which of them are visited. The read pointer walks through the enabled registers in ascending index order and wraps from the highest back to the lowest.

The register contents come from the surrounding controller as input ports: a status source, the byte counter and the addresses of both ports. The unit keeps two status flags of its own, operation-done and interrupt-pending. The engine sets them with one-cycle pulses, and host commands clear them. A restart command puts the pointer back on the lowest enabled register, so a readback can always begin from a known place.

Top module: `dmarb_readback`

## Requirements
- R1: After a synchronous reset, rd_data is 0x00, the mask is 0x7F (all seven registers enabled) and the read pointer is on RR0.
- R2: The byte written after command 0xBB is stored as the mask, not decoded as a command. Bit n of the mask (n = 0..6) enables RRn, and bit 7 is ignored.
- R3: Command 0xA7 moves the pointer to the lowest-numbered enabled register.
- R4: The unit captures the register at the pointer on the clock edge that samples rd_en and shows it on rd_data from the next cycle. On that same edge the pointer moves to the next enabled register above it, and disabled registers are skipped.
- R5: After the highest enabled register is read, the pointer wraps to the lowest enabled register.
- R6: While the mask is zero, every read returns RR0 and the pointer does not move.
- R7: The register map is RR0 status, RR1/RR2 byte count low/high, RR3/RR4 port A address low/high, and RR5/RR6 port B address low/high. Values are taken from the inputs on the read edge.
- R8: The status byte takes bit 0 from the operation flag, bit 3 from the interrupt-pending flag, and every other bit from stat_ext.
- R9: An int_set pulse sets the interrupt-pending flag and command 0xA3 clears it. If both happen in the same cycle, the set wins.
- R10: An op_set pulse sets the operation flag and command 0xCF clears it. If both happen in the same cycle, the set wins.
- R11: Writing a new mask without command 0xA7 does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_data | input | 8 | Command or mask byte |
| rd_en | input | 1 | Control-port read strobe |
| stat_ext | input | 8 | Status bits other than 0 and 3 |
| op_set | input | 1 | Pulse that sets the operation flag |
| int_set | input | 1 | Pulse that sets the interrupt-pending flag |
| byte_cnt | input | 16 | Byte counter value |
| porta_addr | input | 16 | Port A address counter |
| portb_addr | input | 16 | Port B address counter |
| rd_data | output | 8 | Registered readback byte |

## Verification
Two kinds of internal state can go wrong here, and each shows up at the ports in its own way. A pointer that has drifted, or that sits on a disabled register, returns the wrong byte on the very next read; in a fixed sequence the mistake then repeats on every later read. A mask that was captured badly, or a mask-follow flag that is stuck, changes the order of reads after the next restart command. It can also leave a status flag uncleared or wrongly cleared, and that shows on the next read of RR0, one cycle after the strobe.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int NREG = 7;
  localparam int PW   = $clog2(NREG);
  localparam logic [7:0] CMD_MASK_NEXT = 8'hBB;
  localparam logic [7:0] CMD_INIT_READ = 8'hA7;
  localparam logic [7:0] CMD_RST_INT   = 8'hA3;
  localparam logic [7:0] CMD_LOAD      = 8'hCF;
  localparam int ST_OP_BIT  = 0;
  localparam int ST_INT_BIT = 3;
endpackage

// File: rtl/dmarb_cmd_decode.sv
module dmarb_cmd_decode
  import dmarb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [NREG-1:0] mask,
  output logic            follow,
  output logic            init_cmd,
  output logic            rst_int_cmd,
  output logic            load_cmd
);
  logic is_cmd;
  assign is_cmd = wr_en && !follow;

  always_ff @(posedge clk) begin
    if (rst) begin
      follow <= 1'b0;
      mask   <= '1;
    end else if (wr_en) begin
      if (follow) begin
        mask   <= wr_data[NREG-1:0];
        follow <= 1'b0;
      end else if (wr_data == DW'(CMD_MASK_NEXT)) begin
        follow <= 1'b1;
      end
    end
  end

  assign init_cmd    = is_cmd && (wr_data == DW'(CMD_INIT_READ));
  assign rst_int_cmd = is_cmd && (wr_data == DW'(CMD_RST_INT));
  assign load_cmd    = is_cmd && (wr_data == DW'(CMD_LOAD));
endmodule

// File: rtl/dmarb_status.sv
module dmarb_status
  import dmarb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] stat_ext,
  input  logic          op_set,
  input  logic          int_set,
  input  logic          load_cmd,
  input  logic          rst_int_cmd,
  output logic [DW-1:0] status_byte
);
  logic op_flag;
  logic int_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_flag  <= 1'b0;
      int_flag <= 1'b0;
    end else begin
      if (op_set)          op_flag <= 1'b1;
      else if (load_cmd)   op_flag <= 1'b0;
      if (int_set)         int_flag <= 1'b1;
      else if (rst_int_cmd) int_flag <= 1'b0;
    end
  end

  always_comb begin
    status_byte             = stat_ext;
    status_byte[ST_OP_BIT]  = op_flag;
    status_byte[ST_INT_BIT] = int_flag;
  end
endmodule

// File: rtl/dmarb_pointer.sv
module dmarb_pointer
  import dmarb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] mask,
  input  logic            init_cmd,
  input  logic            rd_en,
  output logic [PW-1:0]   ptr
);
  logic [PW-1:0] nxt;
  logic [PW-1:0] lowest;
  logic          found;

  always_comb begin
    nxt   = ptr;
    found = 1'b0;
    for (int k = 1; k <= NREG; k++) begin
      int t;
      t = int'(ptr) + k;
      if (t >= NREG) t = t - NREG;
      if (!found && mask[PW'(t)]) begin
        nxt   = PW'(t);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    lowest = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) lowest = PW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (init_cmd) ptr <= lowest;
    else if (rd_en)    ptr <= nxt;
  end
endmodule

// File: rtl/dmarb_readback.sv
module dmarb_readback
  import dmarb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [DW-1:0] stat_ext,
  input  logic          op_set,
  input  logic          int_set,
  input  logic [2*DW-1:0] byte_cnt,
  input  logic [2*DW-1:0] porta_addr,
  input  logic [2*DW-1:0] portb_addr,
  output logic [DW-1:0] rd_data
);
  localparam int NWORD = (NREG - 1) / 2;

  logic [NREG-1:0] mask;
  logic            follow;
  logic            init_cmd;
  logic            rst_int_cmd;
  logic            load_cmd;
  logic [DW-1:0]   status_byte;
  logic [PW-1:0]   ptr;
  logic [PW-1:0]   sel;
  logic [DW-1:0]   rr [NREG];
  logic [2*DW-1:0] words [NWORD];

  dmarb_cmd_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mask(mask), .follow(follow), .init_cmd(init_cmd),
    .rst_int_cmd(rst_int_cmd), .load_cmd(load_cmd)
  );

  dmarb_status #(.DW(DW)) u_status (
    .clk(clk), .rst(rst), .stat_ext(stat_ext), .op_set(op_set),
    .int_set(int_set), .load_cmd(load_cmd), .rst_int_cmd(rst_int_cmd),
    .status_byte(status_byte)
  );

  dmarb_pointer u_ptr (
    .clk(clk), .rst(rst), .mask(mask), .init_cmd(init_cmd),
    .rd_en(rd_en), .ptr(ptr)
  );

  assign words[0] = byte_cnt;
  assign words[1] = porta_addr;
  assign words[2] = portb_addr;
  assign rr[0]    = status_byte;

  for (genvar w = 0; w < NWORD; w++) begin : g_split
    assign rr[1 + 2*w] = words[w][DW-1:0];
    assign rr[2 + 2*w] = words[w][2*DW-1:DW];
  end

  assign sel = (mask == '0) ? '0 : ptr;

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rr[sel];
  end
endmodule

// File: rtl/dmarb_checker.sv
module dmarb_checker
  import dmarb_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data,
  input logic            rd_en,
  input logic            op_set,
  input logic            int_set,
  input logic [NREG-1:0] mask,
  input logic            follow,
  input logic [PW-1:0]   ptr,
  input logic [DW-1:0]   status_byte
);
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < NREG);

  p_read_lands_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && (mask != '0) |=> mask[ptr]);

  p_mask_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && (mask == '0) |=> $stable(ptr));

  p_init_lowest_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en && !follow && (wr_data == DW'(CMD_INIT_READ)) |=>
      ((mask & ~({NREG{1'b1}} << ptr)) == '0) && (mask[ptr] || (mask == '0)));

  p_mask_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && follow |=> (mask == $past(wr_data[NREG-1:0])) && !follow);

  p_mask_only_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en && follow && !rd_en |=> $stable(ptr));

  p_int_clear_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en && !follow && (wr_data == DW'(CMD_RST_INT)) && !int_set |=>
      !status_byte[ST_INT_BIT]);

  p_op_clear_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en && !follow && (wr_data == DW'(CMD_LOAD)) && !op_set |=>
      !status_byte[ST_OP_BIT]);
endmodule

bind dmarb_readback dmarb_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .op_set(op_set), .int_set(int_set), .mask(mask), .follow(follow),
  .ptr(ptr), .status_byte(status_byte)
);

// File: tb/dmarb_readback_bench.sv
module dmarb_readback_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  stat_ext = 8'hA4;
  logic        op_set = 1'b0;
  logic        int_set = 1'b0;
  logic [15:0] byte_cnt = 16'h2211;
  logic [15:0] porta_addr = 16'h4433;
  logic [15:0] portb_addr = 16'h6655;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  // {mask, first four expected reads after restart}
  localparam logic [39:0] VEC [7] = '{
    {8'h19, 8'hA4, 8'h33, 8'h44, 8'hA4},
    {8'h7F, 8'hA4, 8'h11, 8'h22, 8'h33},
    {8'h40, 8'h66, 8'h66, 8'h66, 8'h66},
    {8'h01, 8'hA4, 8'hA4, 8'hA4, 8'hA4},
    {8'h2A, 8'h11, 8'h33, 8'h55, 8'h11},
    {8'h00, 8'hA4, 8'hA4, 8'hA4, 8'hA4},
    {8'hE6, 8'h11, 8'h22, 8'h55, 8'h66}
  };

  dmarb_readback u_dmarb_readback (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .stat_ext(stat_ext), .op_set(op_set), .int_set(int_set),
    .byte_cnt(byte_cnt), .porta_addr(porta_addr), .portb_addr(portb_addr),
    .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic restart(input logic [7:0] m);
    wr(8'hBB); wr(m); wr(8'hA7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rd_data", rd_data, 8'h00);
    rd(); chk("R1 R7 first read RR0", rd_data, 8'hA4);
    rd(); chk("R1 R7 second read RR1", rd_data, 8'h11);

    // R11: mask 0x19 written, no restart; pointer stays on RR2
    wr(8'hBB); wr(8'h19);
    rd(); chk("R11 pointer kept", rd_data, 8'h22);
    rd(); chk("R4 R11 skip to RR3", rd_data, 8'h33);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 7; v++) begin
      restart(VEC[v][39:32]);
      for (int j = 0; j < 4; j++) begin
        rd();
        chk($sformatf("R2 R3 R4 R5 R6 R7 vec%0d read%0d", v, j),
            rd_data, VEC[v][31-8*j -: 8]);
      end
    end

    // R6: zero mask with pointer left on RR1
    wr(8'hBB); wr(8'h00);
    rd(); chk("R6 zero mask returns RR0", rd_data, 8'hA4);
    rd(); chk("R6 zero mask repeat", rd_data, 8'hA4);

    // status flags
    restart(8'h01);
    @(negedge clk); int_set = 1'b1; @(negedge clk); int_set = 1'b0;
    rd(); chk("R8 R9 int flag set", rd_data, 8'hAC);
    wr(8'hA3);
    rd(); chk("R9 int flag cleared", rd_data, 8'hA4);
    @(negedge clk); op_set = 1'b1; @(negedge clk); op_set = 1'b0;
    rd(); chk("R8 R10 op flag set", rd_data, 8'hA5);
    wr(8'hCF);
    rd(); chk("R10 op flag cleared", rd_data, 8'hA4);
    @(negedge clk); int_set = 1'b1; wr_en = 1'b1; wr_data = 8'hA3;
    @(negedge clk); int_set = 1'b0; wr_en = 1'b0;
    rd(); chk("R9 set wins over clear", rd_data, 8'hAC);
    @(negedge clk); op_set = 1'b1; wr_en = 1'b1; wr_data = 8'hCF;
    @(negedge clk); op_set = 1'b0; wr_en = 1'b0;
    rd(); chk("R10 set wins over clear", rd_data, 8'hAD);
    wr(8'hCF);

    // R2: 0xA3 after 0xBB is a mask, int flag must survive
    restart(8'hA3);
    rd(); chk("R2 byte not decoded, int kept", rd_data, 8'hAC);
    rd(); chk("R2 mask 0x23 RR1", rd_data, 8'h11);
    rd(); chk("R2 mask 0x23 RR5", rd_data, 8'h55);
    rd(); chk("R2 R5 mask 0x23 wrap", rd_data, 8'hAC);
    wr(8'hA3);

    // R8: external status bits; R7: sampling at strobe
    restart(8'h03);
    stat_ext = 8'h59;
    rd(); chk("R8 external bits", rd_data, 8'h50);
    byte_cnt = 16'h2277;
    rd(); chk("R7 sampled at strobe", rd_data, 8'h77);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule